// File: doc/BRIEF.md
# Display Pin Function and Polarity Selector

This block is the last stage in front of eight output pins of an on-screen-display controller. Six of the pins can each carry either a static general-purpose level or one of the display signals produced upstream: blanking, red, green and blue. For every pin a select bit chooses the function. A single data bit then plays one of two roles. In port mode it is the level that the pin drives. In signal mode it sets the polarity of the display signal. Two of the six pins have no display function, so their select bits have no effect. The last two pins are always plain ports.

Alongside the pin stage, the block decodes the blanking style for the character row currently being shown. It takes a two-bit global mode and one flag bit per row (twelve rows). From them it picks character, border or matrix-outline blanking, and reports the choice as a 2-bit code for the pixel pipeline.

All outputs are registered. A change on any input appears at the outputs after the next rising clock edge. Reset drives every pin low.

Top module: `osd_pin_mux`

## Requirements
- R1: On pins 0, 1, 3 and 5, a select bit of 0 makes the pin drive its data bit: 0 gives low and 1 gives high.
- R2: On these pins, a select bit of 1 routes a display signal to the pin. Pin 0 carries blanking, pin 1 red, pin 3 green and pin 5 blue.
- R3: In signal mode, a data bit of 1 gives positive polarity, so the pin equals the signal. A data bit of 0 gives negative polarity, so the pin is the inverted signal.
- R4: Pins 2 and 4 ignore their select bits (select index 2 and 4) and always drive their data bit.
- R5: Pins 6 and 7 have no select bit and always drive data bits 6 and 7.
- R6: The row style code is 0 for character, 1 for border and 2 for matrix-outline. The value 3 never appears.
- R7: The style is chosen from the mode and the row flag as follows. Mode 00 gives matrix-outline for either flag value. Mode 01 gives character for flag 0 and border for flag 1. Mode 10 gives border for flag 0 and matrix-outline for flag 1. Mode 11 gives matrix-outline for flag 0 and character for flag 1.
- R8: The row flag used is bit `row_idx_i` of `row_flags_i` for row indexes 0 to 11. Indexes 12 to 15 use a flag of 0.
- R9: Outputs change only on a rising clock edge, one cycle after the inputs that determine them.
- R10: While reset is asserted, all eight pins are low and the style code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 6 | Function select for pins 0..5 (1 = display signal) |
| lvl_i | input | 8 | Per-pin data bit: level in port mode, polarity in signal mode |
| blank_i | input | 1 | Blanking signal from the display pipeline |
| red_i | input | 1 | Red signal |
| green_i | input | 1 | Green signal |
| blue_i | input | 1 | Blue signal |
| blk_mode_i | input | 2 | Global blanking mode |
| row_flags_i | input | 12 | One style flag per character row |
| row_idx_i | input | 4 | Index of the row being displayed |
| pin_o | output | 8 | Registered pin levels |
| row_style_o | output | 2 | Registered row style code |

## Verification
On every cycle, the in-RTL assertions check several properties. Each pin matches its port level or its polarity-adjusted display signal from the previous cycle. The pins without a display function follow their data bit whatever their select bit. The style code is never 3. Reset holds every output at zero. The full style table, out-of-range row indexes, and the one-cycle latency are shown by the bench's scenarios. There, a behavioural model is compared against the outputs after every clock while the mode, flags, index, select bits and signal patterns are swept.

// File: rtl/osd_pin_pkg.sv
package osd_pin_pkg;

    typedef enum logic [1:0] {
        STYLE_CHAR   = 2'd0,
        STYLE_BORDER = 2'd1,
        STYLE_MATRIX = 2'd2
    } row_style_e;

    // Pins with a display-signal alternate: 0, 1, 3, 5
    localparam logic [7:0] ALT_MASK = 8'b0010_1011;

endpackage

// File: rtl/osd_pin_cell.sv
module osd_pin_cell #(
    parameter bit HAS_ALT = 1'b1
) (
    input  logic sel,
    input  logic lvl,
    input  logic sig,
    output logic val
);
    logic use_sig;

    always_comb begin
        use_sig = HAS_ALT && sel;
        if (use_sig) begin
            // lvl = 1 keeps polarity, lvl = 0 inverts
            val = lvl ? sig : ~sig;
        end else begin
            val = lvl;
        end
    end
endmodule

// File: rtl/osd_row_style.sv
module osd_row_style
    import osd_pin_pkg::*;
#(
    parameter int NUM_ROWS = 12,
    localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic [1:0]          mode,
    input  logic [NUM_ROWS-1:0] flags,
    input  logic [ROW_W-1:0]    idx,
    output row_style_e          style
);
    localparam logic [ROW_W-1:0] ROW_LIMIT = ROW_W'(NUM_ROWS);

    logic flag;

    always_comb begin
        flag = 1'b0;
        if (idx < ROW_LIMIT) begin
            flag = flags[idx];
        end
        unique case (mode)
            2'b00:   style = STYLE_MATRIX;
            2'b01:   style = flag ? STYLE_BORDER : STYLE_CHAR;
            2'b10:   style = flag ? STYLE_MATRIX : STYLE_BORDER;
            default: style = flag ? STYLE_CHAR   : STYLE_MATRIX;
        endcase
    end
endmodule

// File: rtl/osd_pin_mux.sv
module osd_pin_mux
    import osd_pin_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int NUM_SEL  = 6,
    parameter int NUM_ROWS = 12,
    localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SEL-1:0]  sel_i,
    input  logic [NUM_PINS-1:0] lvl_i,
    input  logic                blank_i,
    input  logic                red_i,
    input  logic                green_i,
    input  logic                blue_i,
    input  logic [1:0]          blk_mode_i,
    input  logic [NUM_ROWS-1:0] row_flags_i,
    input  logic [ROW_W-1:0]    row_idx_i,
    output logic [NUM_PINS-1:0] pin_o,
    output logic [1:0]          row_style_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] pins;
        logic [1:0]          style;
    } out_t;

    out_t st_d, st_q;

    logic [NUM_PINS-1:0] sig_vec;
    logic [NUM_PINS-1:0] cell_val;
    row_style_e          style_w;

    // Display-signal source per pin
    always_comb begin
        sig_vec    = '0;
        sig_vec[0] = blank_i;
        sig_vec[1] = red_i;
        sig_vec[3] = green_i;
        sig_vec[5] = blue_i;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic sel_w;
        if (p < NUM_SEL) begin : g_sel
            assign sel_w = sel_i[p];
        end else begin : g_nosel
            assign sel_w = 1'b0;
        end
        osd_pin_cell #(
            .HAS_ALT(ALT_MASK[p])
        ) u_cell (
            .sel(sel_w),
            .lvl(lvl_i[p]),
            .sig(sig_vec[p]),
            .val(cell_val[p])
        );
    end

    osd_row_style #(
        .NUM_ROWS(NUM_ROWS)
    ) u_style (
        .mode (blk_mode_i),
        .flags(row_flags_i),
        .idx  (row_idx_i),
        .style(style_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pins  = cell_val;
        st_d.style = style_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o       = st_q.pins;
    assign row_style_o = st_q.style;

    // ---------------- assertions ----------------
    logic run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |-> (pin_o == '0 && row_style_o == 2'd0));

    assert_style_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        row_style_o != 2'd3);

    assert_port_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !$past(sel_i[0])) |-> pin_o[0] == $past(lvl_i[0]));

    assert_sig_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(sel_i[0])) |->
            pin_o[0] == ($past(lvl_i[0]) ? $past(blank_i) : !$past(blank_i)));

    assert_sig_red_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(sel_i[1])) |->
            pin_o[1] == ($past(lvl_i[1]) ? $past(red_i) : !$past(red_i)));

    assert_sig_green_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(sel_i[3])) |->
            pin_o[3] == ($past(lvl_i[3]) ? $past(green_i) : !$past(green_i)));

    assert_sig_blue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(sel_i[5])) |->
            pin_o[5] == ($past(lvl_i[5]) ? $past(blue_i) : !$past(blue_i)));

    assert_plain_p2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> pin_o[2] == $past(lvl_i[2]));

    assert_plain_p4_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> pin_o[4] == $past(lvl_i[4]));

    assert_plain_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> pin_o[7:6] == $past(lvl_i[7:6]));

endmodule

// File: tb/sim_osd_pin_mux.sv
module sim_osd_pin_mux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  sel_i = '0;
    logic [7:0]  lvl_i = '0;
    logic        blank_i = 1'b0, red_i = 1'b0, green_i = 1'b0, blue_i = 1'b0;
    logic [1:0]  blk_mode_i = '0;
    logic [11:0] row_flags_i = '0;
    logic [3:0]  row_idx_i = '0;
    logic [7:0]  pin_o;
    logic [1:0]  row_style_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    osd_pin_mux u0 (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .lvl_i(lvl_i),
        .blank_i(blank_i), .red_i(red_i), .green_i(green_i), .blue_i(blue_i),
        .blk_mode_i(blk_mode_i), .row_flags_i(row_flags_i),
        .row_idx_i(row_idx_i), .pin_o(pin_o), .row_style_o(row_style_o)
    );

    function automatic logic model_pin(int p);
        logic s;
        bit alt;
        alt = 1;
        case (p)
            0: s = blank_i;
            1: s = red_i;
            3: s = green_i;
            5: s = blue_i;
            default: begin s = 1'b0; alt = 0; end
        endcase
        if (alt && sel_i[p]) return lvl_i[p] ? s : ~s;
        return lvl_i[p];
    endfunction

    function automatic string pin_req(int p);
        if (p == 2 || p == 4) return "R4";
        if (p >= 6) return "R5";
        if (!sel_i[p]) return "R1";
        return lvl_i[p] ? "R2" : "R3";
    endfunction

    function automatic logic [1:0] model_style();
        logic f;
        f = (row_idx_i < 12) ? row_flags_i[row_idx_i] : 1'b0;
        case ({blk_mode_i, f})
            3'b000, 3'b001: return 2'd2;
            3'b010: return 2'd0;
            3'b011: return 2'd1;
            3'b100: return 2'd1;
            3'b101: return 2'd2;
            3'b110: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp, string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // inputs are current; outputs were captured from them at the last edge
    task automatic compare();
        logic [7:0] ep;
        logic [1:0] es;
        for (int p = 0; p < 8; p++) begin
            ep[p] = model_pin(p);
            chk(pin_o[p] === ep[p], pin_req(p), int'(pin_o[p]), int'(ep[p]),
                $sformatf("pin%0d", p));
        end
        es = model_style();
        chk(row_style_o === es, (row_idx_i < 12) ? "R7" : "R8",
            int'(row_style_o), int'(es), "style");
        chk(row_style_o != 2'd3, "R6", int'(row_style_o), 0, "style code legal");
    endtask

    task automatic apply(logic [5:0] s, logic [7:0] l, logic [3:0] sig,
                         logic [1:0] m, logic [11:0] f, logic [3:0] idx);
        sel_i = s; lvl_i = l;
        {blank_i, red_i, green_i, blue_i} = sig;
        blk_mode_i = m; row_flags_i = f; row_idx_i = idx;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R10: reset holds outputs at zero despite busy inputs
        sel_i = 6'h3F; lvl_i = 8'hFF; blk_mode_i = 2'b01; row_flags_i = '1;
        {blank_i, red_i, green_i, blue_i} = 4'hF;
        repeat (3) @(negedge clk);
        chk(pin_o == 8'h00, "R10", int'(pin_o), 0, "pins in reset");
        chk(row_style_o == 2'd0, "R10", int'(row_style_o), 0, "style in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R4/R5 port levels
        apply(6'h00, 8'hA5, 4'h0, 2'b00, 12'h000, 4'd0);
        apply(6'h00, 8'h5A, 4'hF, 2'b00, 12'h000, 4'd0);
        // R4: select bits 2 and 4 set, pins still ports
        apply(6'b010100, 8'b0001_0000, 4'hF, 2'b00, 12'h000, 4'd0);
        apply(6'b010100, 8'b0000_0100, 4'h0, 2'b00, 12'h000, 4'd0);
        // R2/R3: signal mode, positive then negative polarity
        apply(6'h3F, 8'hFF, 4'b1010, 2'b00, 12'h000, 4'd0);
        apply(6'h3F, 8'hFF, 4'b0101, 2'b00, 12'h000, 4'd0);
        apply(6'h3F, 8'h00, 4'b1010, 2'b00, 12'h000, 4'd0);
        apply(6'h3F, 8'h00, 4'b0011, 2'b00, 12'h000, 4'd0);

        // R7: every mode with both flag values, R8 out-of-range rows
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 16; r++) begin
                apply(6'h00, 8'h00, 4'h0, 2'(m), 12'hA5C, 4'(r));
                apply(6'h00, 8'h00, 4'h0, 2'(m), ~12'hA5C, 4'(r));
            end
        end

        // R9: a new input does not reach the pins before the clock edge
        apply(6'h00, 8'h00, 4'h0, 2'b01, 12'h000, 4'd0);
        lvl_i = 8'hFF;
        #2;
        chk(pin_o == 8'h00, "R9", int'(pin_o), 0, "pins before edge");
        @(posedge clk);
        #1;
        chk(pin_o == 8'hFF, "R9", int'(pin_o), 255, "pins after edge");
        @(negedge clk);

        // mixed sweep
        for (int k = 0; k < 300; k++) begin
            apply(6'($urandom), 8'($urandom), 4'($urandom), 2'($urandom),
                  12'($urandom), 4'($urandom));
        end

        // R10: asynchronous reset in mid-run
        apply(6'h00, 8'hFF, 4'h0, 2'b10, 12'hFFF, 4'd3);
        rst_n = 1'b0;
        #1;
        chk(pin_o == 8'h00, "R10", int'(pin_o), 0, "pins on async reset");
        chk(row_style_o == 2'd0, "R10", int'(row_style_o), 0, "style on async reset");
        @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule